// File: doc/BRIEF.md
# Dual-Core Hardware Lock Bank

This block holds a set of one-bit mutual-exclusion locks that two processor cores share. Each core has its own single-cycle access port. Each lock has its own address in a small window. A read of that address is an atomic test-and-set. If the lock is free, the read takes it and returns a one-hot word that marks the lock. If the lock is taken, the read returns zero and changes nothing. A write to the address frees the lock, and the written data does not matter, so the port has no data input.

One extra address returns the state of every lock as a bitmap. Software uses it to observe the locks without disturbing them. Each lock is a two-state machine. `LK_FREE` moves to `LK_HELD` on the *claim* transition, which is a granted read from either core. `LK_HELD` moves to `LK_FREE` on the *release* transition, which is a write from either core. When both cores read the same free lock in the same cycle, core 0 is granted the lock.

Read data is combinational. It comes from the lock state before the clock edge that ends the access, and new state takes effect from the following cycle.

Top module: `lock_bank_top`

## Requirements
- R1: The bank holds `NUM_LOCKS` (default 32) independent locks at addresses 0 to `NUM_LOCKS-1`. An access to one lock never changes another lock.
- R2: A read of a lock in `LK_HELD` returns all zeros, and the lock stays held.
- R3: A read of a lock in `LK_FREE` returns, in the same cycle, a word with only bit `i` set (1 shifted left by the lock index `i`). From the next cycle the lock is in `LK_HELD`.
- R4: A write access to a lock's address moves that lock to `LK_FREE`.
- R5: When both cores read the same free lock in the same cycle, core 0 receives the one-hot word and core 1 receives zero. The lock ends held.
- R6: A read of address `NUM_LOCKS` (32) returns the lock bitmap as it was before the edge, where bit `i` = 1 means lock `i` is held.
- R7: Reset puts every lock in `LK_FREE`.
- R8: A write to a lock that is already free leaves every lock unchanged.
- R9: If one core writes a lock in the same cycle that the other core reads it, the read reports the state before the write. A held lock reads as zero and ends free.
- R10: Reads of the status address change no lock. Writes to the status address or to any address above it are ignored. Reads above the status address, and cycles with no read, return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| c0_en | input | 1 | Core 0 access strobe |
| c0_we | input | 1 | Core 0 write (1) or read (0) |
| c0_addr | input | 6 | Core 0 address |
| c0_rdata | output | 32 | Core 0 read data |
| c1_en | input | 1 | Core 1 access strobe |
| c1_we | input | 1 | Core 1 write (1) or read (0) |
| c1_addr | input | 6 | Core 1 address |
| c1_rdata | output | 32 | Core 1 read data |

## Verification
The assertions check the following on every cycle:
- a granted claim always leaves the lock held, and a held lock is never granted;
- at most one core is granted a lock;
- core 1 reads zero whenever both cores read the same lock;
- a cycle that touches only the status address or unused addresses leaves the bitmap unchanged.

Some behaviours can only be shown by the bench's scenarios against its reference model:
- the exact one-hot return value;
- the pre-release view when a read and a release of the same lock meet in one cycle;
- reset in the middle of a run;
- the bitmap's contents over long random runs with frequent collisions.

// File: rtl/lockbank_pkg.sv
package lockbank_pkg;
    typedef enum logic {
        LK_FREE = 1'b0,
        LK_HELD = 1'b1
    } lock_state_e;
endpackage

// File: rtl/lockbank_decode.sv
module lockbank_decode #(
    parameter int NUM_LOCKS = 32,
    parameter int ADDR_W    = 6
) (
    input  logic                 en,
    input  logic                 we,
    input  logic [ADDR_W-1:0]    addr,
    output logic [NUM_LOCKS-1:0] rd_vec,
    output logic [NUM_LOCKS-1:0] wr_vec,
    output logic                 status_rd
);
    localparam logic [ADDR_W-1:0] STATUS_ADDR = ADDR_W'(NUM_LOCKS);

    logic rd_access;
    logic wr_access;

    assign rd_access = en & ~we;
    assign wr_access = en & we;
    assign status_rd = rd_access & (addr == STATUS_ADDR);

    for (genvar i = 0; i < NUM_LOCKS; i++) begin : g_sel
        assign rd_vec[i] = rd_access & (addr == ADDR_W'(i));
        assign wr_vec[i] = wr_access & (addr == ADDR_W'(i));
    end

    // R10: the status address never selects a lock
    always_comb begin
        if (status_rd) assert ((rd_vec | wr_vec) == '0);
    end
endmodule

// File: rtl/lockbank_cell.sv
module lockbank_cell
    import lockbank_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rd0,
    input  logic rd1,
    input  logic wr0,
    input  logic wr1,
    output logic held,
    output logic grant0,
    output logic grant1
);
    lock_state_e state_q;
    lock_state_e state_d;
    logic        claim;
    logic        release_req;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LK_FREE;
        else        state_q <= state_d;
    end

    // grants and next state
    always_comb begin
        grant0      = 1'b0;
        grant1      = 1'b0;
        release_req = wr0 | wr1;
        state_d     = state_q;
        unique case (state_q)
            LK_FREE: begin
                grant0 = rd0;
                grant1 = rd1 & ~rd0;
                if (rd0 | rd1) state_d = LK_HELD;
            end
            LK_HELD: begin
                if (release_req) state_d = LK_FREE;
            end
            default: state_d = LK_FREE;
        endcase
        claim = grant0 | grant1;
    end

    assign held = (state_q == LK_HELD);

    p_held_read_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        held && (rd0 || rd1) |-> !grant0 && !grant1);
    p_claim_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
        claim |=> held);
    p_release_frees_r4: assert property (@(posedge clk) disable iff (!rst_n)
        release_req && !claim |=> !held);
    p_single_grant_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({grant0, grant1}));
endmodule

// File: rtl/lock_bank_top.sv
module lock_bank_top #(
    parameter int NUM_LOCKS = 32,
    parameter int ADDR_W    = $clog2(NUM_LOCKS) + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 c0_en,
    input  logic                 c0_we,
    input  logic [ADDR_W-1:0]    c0_addr,
    output logic [NUM_LOCKS-1:0] c0_rdata,
    input  logic                 c1_en,
    input  logic                 c1_we,
    input  logic [ADDR_W-1:0]    c1_addr,
    output logic [NUM_LOCKS-1:0] c1_rdata
);
    logic [NUM_LOCKS-1:0] rd0_vec, wr0_vec, rd1_vec, wr1_vec;
    logic [NUM_LOCKS-1:0] held_vec, grant0_vec, grant1_vec;
    logic                 status0, status1;

    lockbank_decode #(.NUM_LOCKS(NUM_LOCKS), .ADDR_W(ADDR_W)) dec0_i (
        .en(c0_en), .we(c0_we), .addr(c0_addr),
        .rd_vec(rd0_vec), .wr_vec(wr0_vec), .status_rd(status0));

    lockbank_decode #(.NUM_LOCKS(NUM_LOCKS), .ADDR_W(ADDR_W)) dec1_i (
        .en(c1_en), .we(c1_we), .addr(c1_addr),
        .rd_vec(rd1_vec), .wr_vec(wr1_vec), .status_rd(status1));

    for (genvar i = 0; i < NUM_LOCKS; i++) begin : g_lock
        lockbank_cell cell_i (
            .clk(clk), .rst_n(rst_n),
            .rd0(rd0_vec[i]), .rd1(rd1_vec[i]),
            .wr0(wr0_vec[i]), .wr1(wr1_vec[i]),
            .held(held_vec[i]), .grant0(grant0_vec[i]), .grant1(grant1_vec[i]));
    end

    // one-hot grant word doubles as the success value
    always_comb begin
        c0_rdata = status0 ? held_vec : grant0_vec;
        c1_rdata = status1 ? held_vec : grant1_vec;
    end

    p_tie_core0_r5: assert property (@(posedge clk) disable iff (!rst_n)
        c0_en && !c0_we && c1_en && !c1_we && (c0_addr == c1_addr)
        && (c0_addr < ADDR_W'(NUM_LOCKS)) |-> c1_rdata == '0);
    p_status_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!c0_en || c0_addr >= ADDR_W'(NUM_LOCKS)) &&
        (!c1_en || c1_addr >= ADDR_W'(NUM_LOCKS)) |=> $stable(held_vec));
endmodule

// File: tb/lock_bank_top_tb_top.sv
module lock_bank_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        c0_en = 1'b0, c0_we = 1'b0, c1_en = 1'b0, c1_we = 1'b0;
    logic [5:0]  c0_addr = '0, c1_addr = '0;
    logic [31:0] c0_rdata, c1_rdata;

    int checks = 0;
    int errors = 0;
    logic [31:0] model = '0;

    always #4 clk = ~clk;

    lock_bank_top dut_i (
        .clk(clk), .rst_n(rst_n),
        .c0_en(c0_en), .c0_we(c0_we), .c0_addr(c0_addr), .c0_rdata(c0_rdata),
        .c1_en(c1_en), .c1_we(c1_we), .c1_addr(c1_addr), .c1_rdata(c1_rdata));

    function automatic logic [31:0] expect_rd(bit is_c1, bit e, bit w, int a,
                                              bit oe, bit ow, int oa);
        if (!e || w) return '0;
        if (a < 32) begin
            if (model[a]) return '0;
            if (is_c1 && oe && !ow && oa == a) return '0;
            return 32'h1 << a;
        end
        if (a == 32) return model;
        return '0;
    endfunction

    task automatic check(string tag, string who, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, who, act, exp);
        end
    endtask

    task automatic step(bit e0, bit w0, int a0, bit e1, bit w1, int a1, string tag);
        logic [31:0] nxt;
        c0_en = e0; c0_we = w0; c0_addr = 6'(a0);
        c1_en = e1; c1_we = w1; c1_addr = 6'(a1);
        #2;
        check(tag, "core0", c0_rdata, expect_rd(1'b0, e0, w0, a0, e1, w1, a1));
        check(tag, "core1", c1_rdata, expect_rd(1'b1, e1, w1, a1, e0, w0, a0));
        nxt = model;
        for (int i = 0; i < 32; i++) begin
            bit rd = (e0 && !w0 && a0 == i) || (e1 && !w1 && a1 == i);
            bit wr = (e0 && w0 && a0 == i) || (e1 && w1 && a1 == i);
            if (!model[i] && rd) nxt[i] = 1'b1;
            else if (model[i] && wr) nxt[i] = 1'b0;
        end
        model = nxt;
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        c0_en = 1'b0; c1_en = 1'b0;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        model = '0;
        @(negedge clk);
    endtask

    initial begin
        #800000;
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        step(1, 0, 32, 1, 0, 32, "R7 reset bitmap");
        step(1, 0, 5, 0, 0, 0, "R3 claim lock 5");
        step(0, 0, 0, 1, 0, 5, "R2 held read");
        step(0, 0, 0, 1, 0, 32, "R6 status after claim");
        step(0, 0, 0, 1, 1, 5, "R4 release lock 5");
        step(0, 0, 0, 1, 0, 5, "R4 reclaim after release");
        step(1, 0, 9, 1, 0, 9, "R5 tie on lock 9");
        step(1, 0, 32, 1, 1, 3, "R8 release of free lock");
        step(1, 0, 32, 0, 0, 0, "R8 bitmap unchanged");
        step(1, 1, 9, 1, 0, 9, "R9 release meets read");
        step(1, 0, 32, 1, 0, 32, "R9 lock 9 now free");
        step(1, 0, 31, 1, 0, 0, "R1 edge locks");
        step(1, 0, 1, 0, 0, 0, "R1 neighbour independent");
        step(1, 1, 32, 1, 1, 40, "R10 writes ignored");
        step(1, 0, 50, 1, 0, 32, "R10 unused read");
        step(1, 0, 32, 0, 0, 0, "R10 status stable");
        do_reset();
        step(1, 0, 32, 1, 0, 32, "R7 reset mid run");
        for (int n = 0; n < 4000; n++) begin
            int a0 = (($urandom % 8) == 0) ? 32 + ($urandom % 32) : $urandom % 6;
            int a1 = (($urandom % 8) == 0) ? 32 + ($urandom % 32) : $urandom % 6;
            step(bit'($urandom % 4 != 0), bit'($urandom % 2), a0,
                 bit'($urandom % 4 != 0), bit'($urandom % 2), a1,
                 "R2 R3 R5 R9 random");
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule